// File: doc/BRIEF.md
# Power-Fail Write-Protect Sequencer

This block supervises a battery-backed static memory. Two analog comparators report whether the supply is above the write-protect threshold and whether it is above the battery switchover level. Both flags are asynchronous. The block synchronizes them and filters them, then steps through five states: unpowered, battery retention, protected, recovering and normal. It gates the host's chip, write and output enables before they reach the array. It also drives a write-block flag, an output tri-state force and a battery-select signal.

A loss of supply locks the array out within a few clock cycles. A return of supply must first pass a debounce window. After that, reads stay blocked for an enable-hold interval, and writes stay blocked for a longer recovery interval. If the supply drops again during recovery, the block returns to the protected state, and the recovery count starts over on the next valid rise.

A sticky seal flag models a battery that leaves the factory disconnected. The flag is set by the first validated power-up. Only after that may the battery be selected when the supply falls below the switchover level. Reset returns the seal to its factory state. All intervals are parameters in clock cycles: `DEB_CYC` for debounce, `HOLD_CYC` for enable hold and `REC_CYC` for recovery, with `HOLD_CYC < REC_CYC`.

Top module: `pwrfail_guard`

## Requirements
- R1: After reset the block is unpowered: wr_block=1, out_hiz=1, batt_sel=0, seal_open=0, and arr_ce, arr_we and arr_oe are all 0.
- R2: When wp_ok_raw falls, wr_block and out_hiz are both 1 on the 4th rising clock edge after the change (two synchronizer stages, the filter, then the state register), with no debounce delay.
- R3: A rise of either comparator flag takes effect only after it has been high at the synchronizer output for DEB_CYC consecutive cycles. A high pulse shorter than DEB_CYC cycles changes neither seal_open nor wr_block.
- R4: After a valid rise of wp_ok_raw with sw_ok_raw high, out_hiz falls on edge DEB_CYC+3+HOLD_CYC, counted from the change.
- R5: After the same rise, wr_block falls on edge DEB_CYC+3+REC_CYC.
- R6: If wp_ok_raw falls during the recovery interval, out_hiz returns to 1 within 4 edges. The next valid rise then restarts the full R4/R5 timing from zero.
- R7: seal_open becomes 1 on the first validated rise of the write-protect flag while the switchover flag is high. It stays 1 through later supply losses until reset.
- R8: While the filtered switchover flag is low, batt_sel equals seal_open. In every other state, batt_sel is 0.
- R9: The enables to the array are gated as follows. arr_ce = host_ce & !out_hiz. arr_we = host_ce & host_we & !wr_block. arr_oe = host_ce & host_oe & !host_we & !out_hiz.
- R10: A low switchover flag takes priority over a high write-protect flag. In that case the block stays locked out, and the seal is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Active-low asynchronous reset, also restores the factory seal |
| wp_ok_raw | input | 1 | Asynchronous comparator: supply above write-protect threshold |
| sw_ok_raw | input | 1 | Asynchronous comparator: supply above battery switchover level |
| host_ce | input | 1 | Host chip enable, active high |
| host_we | input | 1 | Host write enable, active high |
| host_oe | input | 1 | Host output enable, active high |
| arr_ce | output | 1 | Gated chip enable to the array |
| arr_we | output | 1 | Gated write enable to the array |
| arr_oe | output | 1 | Gated output enable to the array |
| wr_block | output | 1 | Internal write inhibit |
| out_hiz | output | 1 | Force data outputs to high impedance |
| batt_sel | output | 1 | Connect the battery to the array |
| seal_open | output | 1 | Sticky flag: battery backup armed |

## Verification
The hardest case to reach is a supply drop inside the recovery window, after the enable hold has already released reads but before writes are released. The bench raises the write-protect flag and waits a fixed number of edges, chosen to land between the two thresholds. It then drops the flag and checks that outputs are forced off again. Finally it re-raises the flag and measures the release edges once more, so that a timer which failed to restart shows up as an early release. The glitch and priority cases are reached the same way: the bench holds the comparator inputs in patterns that a real supply rarely produces.

// File: rtl/pwrfail_guard_pkg.sv
package pwrfail_guard_pkg;

  typedef enum logic [2:0] {
    PG_OFF    = 3'd0,
    PG_RETAIN = 3'd1,
    PG_PROT   = 3'd2,
    PG_RECOV  = 3'd3,
    PG_NORMAL = 3'd4
  } pg_state_e;

  // counter width able to hold the value n
  function automatic int cnt_bits(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/pfg_flag_filter.sv
module pfg_flag_filter #(
  parameter int DEB_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic flag_o
);
  localparam int CW = pwrfail_guard_pkg::cnt_bits(DEB_CYC);
  localparam logic [CW-1:0] LAST = CW'(DEB_CYC - 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;
  logic          flag_q;
  logic          sync_hi;
  logic          settled;

  assign sync_hi = sync_q[1];
  assign settled = (run_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      run_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (!sync_hi) begin
        flag_q <= 1'b0;          // fail-safe: drops pass at once
        run_q  <= '0;
      end else if (!flag_q) begin
        if (settled) begin
          flag_q <= 1'b1;
          run_q  <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end
    end
  end

  assign flag_o = flag_q;

  assert_fast_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_hi |=> !flag_q);
  assert_rise_needs_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(sync_hi));
endmodule

// File: rtl/pfg_recovery_timer.sv
module pfg_recovery_timer #(
  parameter int HOLD_CYC = 10,
  parameter int REC_CYC  = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic hold_done_o,
  output logic rec_done_o
);
  localparam int CW = pwrfail_guard_pkg::cnt_bits(REC_CYC);
  localparam logic [CW-1:0] REC_LAST = CW'(REC_CYC - 1);
  localparam logic [CW-1:0] HOLD_AT  = CW'(HOLD_CYC);

  logic [CW-1:0] cnt_q;

  assign rec_done_o  = run_i && (cnt_q == REC_LAST);
  assign hold_done_o = run_i && (cnt_q >= HOLD_AT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run_i)       cnt_q <= '0;   // any exit restarts the interval
    else if (!rec_done_o)  cnt_q <= cnt_q + 1'b1;
  end

  assert_hold_before_rec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rec_done_o |-> hold_done_o);
  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !hold_done_o);
endmodule

// File: rtl/pwrfail_guard.sv
module pwrfail_guard #(
  parameter int DEB_CYC  = 4,
  parameter int HOLD_CYC = 10,
  parameter int REC_CYC  = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wp_ok_raw,
  input  logic sw_ok_raw,
  input  logic host_ce,
  input  logic host_we,
  input  logic host_oe,
  output logic arr_ce,
  output logic arr_we,
  output logic arr_oe,
  output logic wr_block,
  output logic out_hiz,
  output logic batt_sel,
  output logic seal_open
);
  import pwrfail_guard_pkg::*;
  localparam int NFLAG = 2;

  logic [NFLAG-1:0] raw_v, filt_v;
  logic wp_f, sw_f;
  logic hold_done, rec_done, in_recov;
  pg_state_e state_q, state_d;
  logic seal_q;

  assign raw_v = {sw_ok_raw, wp_ok_raw};

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    pfg_flag_filter #(.DEB_CYC(DEB_CYC)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw_i(raw_v[g]), .flag_o(filt_v[g]));
  end

  assign wp_f = filt_v[0];
  assign sw_f = filt_v[1];
  assign in_recov = (state_q == PG_RECOV);

  pfg_recovery_timer #(.HOLD_CYC(HOLD_CYC), .REC_CYC(REC_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run_i(in_recov),
    .hold_done_o(hold_done), .rec_done_o(rec_done));

  always_comb begin
    state_d = state_q;
    if (!sw_f)      state_d = seal_q ? PG_RETAIN : PG_OFF;
    else if (!wp_f) state_d = PG_PROT;
    else begin
      case (state_q)
        PG_NORMAL: state_d = PG_NORMAL;
        PG_RECOV:  state_d = rec_done ? PG_NORMAL : PG_RECOV;
        default:   state_d = PG_RECOV;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PG_OFF;
      seal_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (wp_f && sw_f) seal_q <= 1'b1;
    end
  end

  assign wr_block  = (state_q != PG_NORMAL);
  assign out_hiz   = !((state_q == PG_NORMAL) || hold_done);
  assign batt_sel  = (state_q == PG_RETAIN);
  assign seal_open = seal_q;

  assign arr_ce = host_ce && !out_hiz;
  assign arr_we = host_ce && host_we && !wr_block;
  assign arr_oe = host_ce && host_oe && !host_we && !out_hiz;

  assert_seal_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(seal_q) |-> seal_q);
  assert_batt_needs_seal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    batt_sel |-> seal_q);
  assert_release_after_timer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PG_NORMAL && $past(state_q) != PG_NORMAL) |-> $past(rec_done));
  assert_lock_on_loss_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_f |=> state_q != PG_NORMAL);
  assert_no_write_unsealed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> seal_q);
  assert_low_sw_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_f |=> (state_q == PG_OFF || state_q == PG_RETAIN));
endmodule

// File: tb/pwrfail_guard_tb_top.sv
module pwrfail_guard_tb_top;
  localparam int DEB  = 4;
  localparam int HOLD = 10;
  localparam int REC  = 40;
  localparam int T_HIZ = DEB + 3 + HOLD;
  localparam int T_WR  = DEB + 3 + REC;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wp_ok_raw = 1'b0, sw_ok_raw = 1'b0;
  logic host_ce = 1'b0, host_we = 1'b0, host_oe = 1'b0;
  logic arr_ce, arr_we, arr_oe, wr_block, out_hiz, batt_sel, seal_open;
  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pwrfail_guard #(.DEB_CYC(DEB), .HOLD_CYC(HOLD), .REC_CYC(REC)) dut_i (
    .clk(clk), .rst_n(rst_n), .wp_ok_raw(wp_ok_raw), .sw_ok_raw(sw_ok_raw),
    .host_ce(host_ce), .host_we(host_we), .host_oe(host_oe),
    .arr_ce(arr_ce), .arr_we(arr_we), .arr_oe(arr_oe), .wr_block(wr_block),
    .out_hiz(out_hiz), .batt_sel(batt_sel), .seal_open(seal_open));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wp_ok_raw = 1'b0; sw_ok_raw = 1'b0;
    host_ce = 1'b0; host_we = 1'b0; host_oe = 1'b0;
    edges(2);
    @(negedge clk) rst_n = 1'b1;
    edges(1);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk(wr_block && out_hiz, "R1 lockout", {wr_block, out_hiz}, 3);
    chk(!batt_sel && !seal_open, "R1 seal/batt", {batt_sel, seal_open}, 0);
    chk(!arr_ce && !arr_we && !arr_oe, "R1 enables", {arr_ce, arr_we, arr_oe}, 0);
  endtask

  // R10: wp high with sw low stays locked and unsealed
  task automatic t_priority();
    do_reset();
    @(negedge clk) wp_ok_raw = 1'b1;
    edges(30);
    chk(!seal_open, "R10 seal", seal_open, 0);
    chk(wr_block && out_hiz, "R10 lockout", {wr_block, out_hiz}, 3);
    // R8: unsealed battery stays disconnected below switchover
    chk(!batt_sel, "R8 unsealed", batt_sel, 0);
  endtask

  // R3: short pulse ignored
  task automatic t_glitch();
    do_reset();
    @(negedge clk) sw_ok_raw = 1'b1;
    edges(20);
    @(negedge clk) wp_ok_raw = 1'b1;
    repeat (DEB - 1) @(negedge clk);
    wp_ok_raw = 1'b0;
    edges(REC + 20);
    chk(!seal_open, "R3 seal", seal_open, 0);
    chk(wr_block, "R3 wr_block", wr_block, 1);
  endtask

  // R4, R5, R7, R9: timed release, measured from the input change
  task automatic powerup(input string tag);
    int t_h = -1, t_w = -1, bad = 0;
    host_ce = 1'b1; host_we = 1'b1; host_oe = 1'b0;
    @(negedge clk) wp_ok_raw = 1'b1;
    for (int n = 1; n <= T_WR + 10; n++) begin
      @(posedge clk); #1;
      if (t_h < 0 && !out_hiz) t_h = n;
      if (t_w < 0 && !wr_block) t_w = n;
      if (arr_ce != (n >= T_HIZ) || arr_we != (n >= T_WR)) bad++;
    end
    chk(t_h == T_HIZ, {"R4 hiz release ", tag}, t_h, T_HIZ);
    chk(t_w == T_WR, {"R5 write release ", tag}, t_w, T_WR);
    chk(bad == 0, {"R9 gating during recovery ", tag}, bad, 0);
    chk(seal_open, {"R7 seal set ", tag}, seal_open, 1);
  endtask

  task automatic t_powerup();
    do_reset();
    @(negedge clk) sw_ok_raw = 1'b1;
    edges(20);
    powerup("first");
  endtask

  task automatic t_gating();
    @(negedge clk) begin host_ce = 1; host_we = 0; host_oe = 1; end
    #1 chk(arr_oe && arr_ce && !arr_we, "R9 read", {arr_ce, arr_we, arr_oe}, 5);
    @(negedge clk) begin host_ce = 1; host_we = 1; host_oe = 1; end
    #1 chk(!arr_oe && arr_we, "R9 write", {arr_ce, arr_we, arr_oe}, 6);
    @(negedge clk) begin host_ce = 0; host_we = 1; host_oe = 1; end
    #1 chk(!arr_ce && !arr_we && !arr_oe, "R9 deselect", {arr_ce, arr_we, arr_oe}, 0);
  endtask

  // R2: fast lockout
  task automatic t_loss();
    int t = -1;
    @(negedge clk) begin host_ce = 1; host_we = 1; host_oe = 0; wp_ok_raw = 1'b0; end
    for (int n = 1; n <= 10; n++) begin
      @(posedge clk); #1;
      if (t < 0 && wr_block) begin
        t = n;
        chk(out_hiz && !arr_we && !arr_ce, "R2 outputs forced", {out_hiz, arr_we, arr_ce}, 4);
      end
    end
    chk(t == 4, "R2 lock edge", t, 4);
  endtask

  // R6: drop inside recovery after hold release
  task automatic t_restart();
    @(negedge clk) wp_ok_raw = 1'b1;
    edges(T_HIZ + 5);
    chk(!out_hiz && wr_block, "R6 in window", {out_hiz, wr_block}, 1);
    @(negedge clk) wp_ok_raw = 1'b0;
    edges(4);
    chk(out_hiz, "R6 re-lock", out_hiz, 1);
    edges(10);
    powerup("restart R6");
  endtask

  // R7, R8: retention after sealing
  task automatic t_retain();
    @(negedge clk) begin wp_ok_raw = 1'b0; sw_ok_raw = 1'b0; end
    edges(4);
    chk(batt_sel, "R8 battery select", batt_sel, 1);
    chk(seal_open, "R7 sticky", seal_open, 1);
    @(negedge clk) sw_ok_raw = 1'b1;
    edges(DEB + 4);
    chk(!batt_sel && wr_block, "R8 back on supply", {batt_sel, wr_block}, 1);
  endtask

  initial begin
    t_reset_state();
    t_priority();
    t_glitch();
    t_powerup();
    t_gating();
    t_loss();
    t_restart();
    t_retain();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule